// File: doc/BRIEF.md
# Indirect GPIO Port Controller

This block owns twenty-two general-purpose pins split into three banks: bank A (pins 10 to 17), bank B (pins 20 to 25) and bank C (pins 30 to 37). The host reaches pin data through a pair of byte ports. The first is a pointer register. The second is a window onto the bank that the pointer selects. Address decoding of the two ports happens outside the block and arrives as a select strobe plus a one-bit port selector. A separate enable input opens or closes the whole port pair.

Each pin has its own configuration byte, supplied from outside as a packed bus. Within that byte, one bit makes the pin an input, one bit inverts its polarity, and one bit hands the pad over to a special-function source. The block computes every pad's output value and output enable from that byte, from the GPIO output latch and from the special-function inputs. For input pins, the pad level (after inversion) is returned to the host. Software changes a single pin by reading the bank, editing one bit and writing the byte back.

Top module: `gpio_ix_ctrl`

## Requirements
- R1: After reset the pointer register reads 0x00 and every bank output latch holds zero.
- R2: A write to port 0 (addr_i=0) stores all eight bits of wdata_i in the pointer, and a read of port 0 returns that value.
- R3: A write to port 1 updates the output latch of the bank the pointer selects. Pointer 0x01 selects bank A, 0x02 selects bank B and 0x03 selects bank C, and bit n of the byte belongs to pin bank*10+n.
- R4: A pin whose configuration byte has bit 0 (input), bit 1 (invert) and bit 3 (special) all clear drives pad_oe high and pad_o equal to its latch bit. With bit 1 set, pad_o is the latch bit inverted. In both cases a read of its bank returns the latch bit.
- R5: A pin with configuration bit 0 set and bit 3 clear drives pad_oe low, and a bank read returns its pad level XOR configuration bit 1.
- R6: Bank B has six pins, so bits 7 and 6 of a bank B read are always 0 and written values there are dropped.
- R7: A pin with configuration bit 3 set takes pad_o from spec_o_i and pad_oe from spec_oe_i, and its invert bit and latch have no effect on the pad. The latch still accepts writes, and those writes take effect on the pad once bit 3 is cleared.
- R8: With the pointer outside 0x01 to 0x03, a port 1 read returns 0x00 and a port 1 write changes no latch.
- R9: While port_en_i is low, writes to either port are ignored and rdata_o is 0x00.
- R10: rdata_o is 0x00 in every cycle without both sel_i and rd_i high.
- R11: A read-modify-write of one bit through port 1 changes only that pin's latch bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Port pair selected by the external decoder |
| port_en_i | input | 1 | Port pair enable |
| addr_i | input | 1 | 0 = pointer port, 1 = data port |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (combinational) |
| cfg_i | input | 176 | Per-pin configuration bytes, pin p at bits [8p+7:8p], pins packed A then B then C |
| pad_in_i | input | 22 | Pad input levels, bit p = flat pin p |
| spec_o_i | input | 22 | Special-function output values |
| spec_oe_i | input | 22 | Special-function output enables |
| pad_o | output | 22 | Pad output values |
| pad_oe | output | 22 | Pad output enables |

## Verification
A host write into the latch of a pin that is currently in special mode happens in the same cycle as the pad being driven by the special-function source. The bench writes a latch value opposite to spec_o_i while the pin is special, and confirms during that write that the pad still follows the special source. It then clears the special bit and confirms that the pad shows the latch value written earlier. The same question arises for an input pin whose latch is written while its readback comes from the pad: the vector table covers that case by making latch and pad disagree.

// File: rtl/gpio_ix_pkg.sv
package gpio_ix_pkg;
   localparam int BYTE_W      = 8;
   localparam int CFG_IS_IN   = 0;
   localparam int CFG_INVERT  = 1;
   localparam int CFG_SPECIAL = 3;
   localparam int MAX_BANK_W  = 8;

   // pointer code that selects bank g (first bank answers to 1)
   function automatic logic [BYTE_W-1:0] bank_code(int g);
      return BYTE_W'(g + 1);
   endfunction
endpackage

// File: rtl/gpio_ix_host.sv
module gpio_ix_host
   import gpio_ix_pkg::*;
#(
   parameter int NBANK = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_wr,
   input  logic              addr,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] idx_q,
   output logic [NBANK-1:0]  bank_wr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         idx_q <= '0;
      else if (acc_wr && !addr)
         idx_q <= wdata;
   end

   for (genvar g = 0; g < NBANK; g++) begin : g_stb
      assign bank_wr[g] = acc_wr && addr && (idx_q == bank_code(g));
   end
endmodule

// File: rtl/gpio_ix_bank.sv
module gpio_ix_bank
   import gpio_ix_pkg::*;
#(
   parameter int W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [W-1:0]      wdata,
   input  logic [W*8-1:0]    cfg,
   input  logic [W-1:0]      pad_in,
   input  logic [W-1:0]      spec_o,
   input  logic [W-1:0]      spec_oe,
   output logic [W-1:0]      pad_o,
   output logic [W-1:0]      pad_oe,
   output logic [BYTE_W-1:0] rd_val
);
   if (W < 1 || W > MAX_BANK_W) begin : g_bad_w
      $error("gpio_ix_bank: W out of range");
   end

   logic [W-1:0] latch_q;
   logic [W-1:0] rd_bits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         latch_q <= '0;
      else if (wr_stb)
         latch_q <= wdata;
   end

   for (genvar b = 0; b < W; b++) begin : g_pin
      logic [7:0] c;
      logic       is_in, inv, spec;
      logic       unused_cfg;
      assign c          = cfg[b*8 +: 8];
      assign is_in      = c[CFG_IS_IN];
      assign inv        = c[CFG_INVERT];
      assign spec       = c[CFG_SPECIAL];
      assign unused_cfg = ^{c[2], c[7:4]};
      assign pad_o[b]   = spec ? spec_o[b]  : (latch_q[b] ^ inv);
      assign pad_oe[b]  = spec ? spec_oe[b] : ~is_in;
      assign rd_bits[b] = is_in ? (pad_in[b] ^ inv) : latch_q[b];
   end

   if (W < BYTE_W) begin : g_pad
      assign rd_val = {{(BYTE_W-W){1'b0}}, rd_bits};
   end else begin : g_full
      assign rd_val = rd_bits;
   end
endmodule

// File: rtl/gpio_ix_ctrl.sv
module gpio_ix_ctrl
   import gpio_ix_pkg::*;
#(
   parameter int BANK_A_W = 8,
   parameter int BANK_B_W = 6,
   parameter int BANK_C_W = 8,
   localparam int NPIN    = BANK_A_W + BANK_B_W + BANK_C_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_i,
   input  logic              port_en_i,
   input  logic              addr_i,
   input  logic              wr_i,
   input  logic              rd_i,
   input  logic [7:0]        wdata_i,
   output logic [7:0]        rdata_o,
   input  logic [NPIN*8-1:0] cfg_i,
   input  logic [NPIN-1:0]   pad_in_i,
   input  logic [NPIN-1:0]   spec_o_i,
   input  logic [NPIN-1:0]   spec_oe_i,
   output logic [NPIN-1:0]   pad_o,
   output logic [NPIN-1:0]   pad_oe
);
   localparam int NBANK = 3;
   localparam int BW [NBANK] = '{BANK_A_W, BANK_B_W, BANK_C_W};

   function automatic int bank_off(int g);
      int s = 0;
      for (int i = 0; i < g; i++) s += BW[i];
      return s;
   endfunction

   logic              acc_wr, acc_rd;
   logic [BYTE_W-1:0] idx_q;
   logic [NBANK-1:0]  bank_wr;
   logic [BYTE_W-1:0] bank_rd [NBANK];
   logic [BYTE_W-1:0] data_view;

   assign acc_wr = sel_i && port_en_i && wr_i;
   assign acc_rd = sel_i && port_en_i && rd_i;

   gpio_ix_host #(.NBANK(NBANK)) u_host (
      .clk     (clk),
      .rst_n   (rst_n),
      .acc_wr  (acc_wr),
      .addr    (addr_i),
      .wdata   (wdata_i),
      .idx_q   (idx_q),
      .bank_wr (bank_wr)
   );

   for (genvar g = 0; g < NBANK; g++) begin : g_bank
      localparam int W   = BW[g];
      localparam int OFF = bank_off(g);
      gpio_ix_bank #(.W(W)) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_stb  (bank_wr[g]),
         .wdata   (wdata_i[W-1:0]),
         .cfg     (cfg_i[OFF*8 +: W*8]),
         .pad_in  (pad_in_i[OFF +: W]),
         .spec_o  (spec_o_i[OFF +: W]),
         .spec_oe (spec_oe_i[OFF +: W]),
         .pad_o   (pad_o[OFF +: W]),
         .pad_oe  (pad_oe[OFF +: W]),
         .rd_val  (bank_rd[g])
      );
   end

   always_comb begin
      data_view = '0;
      for (int g = 0; g < NBANK; g++)
         if (idx_q == bank_code(g)) data_view = bank_rd[g];
   end

   assign rdata_o = !acc_rd ? '0 : (addr_i ? data_view : idx_q);
endmodule

// File: rtl/gpio_ix_chk.sv
module gpio_ix_chk #(
   parameter int NPIN = 22
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sel_i,
   input logic              port_en_i,
   input logic              addr_i,
   input logic              wr_i,
   input logic              rd_i,
   input logic [7:0]        wdata_i,
   input logic [7:0]        rdata_o,
   input logic [7:0]        idx,
   input logic [NPIN*8-1:0] cfg_i,
   input logic [NPIN-1:0]   spec_o_i,
   input logic [NPIN-1:0]   spec_oe_i,
   input logic [NPIN-1:0]   pad_o,
   input logic [NPIN-1:0]   pad_oe
);
   // R9
   port_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !port_en_i |-> rdata_o == 8'h00);

   // R10
   idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(sel_i && rd_i) |-> rdata_o == 8'h00);

   // R2
   ptr_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i && port_en_i && wr_i && !addr_i) |=>
      (!(sel_i && port_en_i && rd_i && !addr_i) || rdata_o == $past(wdata_i)));

   // R8
   bad_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i && port_en_i && rd_i && addr_i && (idx == 8'h00 || idx > 8'h03))
      |-> rdata_o == 8'h00);

   // R6
   bank_b_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i && port_en_i && rd_i && addr_i && idx == 8'h02)
      |-> rdata_o[7:6] == 2'b00);

   for (genvar p = 0; p < NPIN; p++) begin : g_pin
      // R7
      special_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
         cfg_i[p*8+3] |-> (pad_o[p] == spec_o_i[p] && pad_oe[p] == spec_oe_i[p]));
      // R5
      input_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_i[p*8] && !cfg_i[p*8+3]) |-> !pad_oe[p]);
   end
endmodule

bind gpio_ix_ctrl gpio_ix_chk #(.NPIN(NPIN)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sel_i     (sel_i),
   .port_en_i (port_en_i),
   .addr_i    (addr_i),
   .wr_i      (wr_i),
   .rd_i      (rd_i),
   .wdata_i   (wdata_i),
   .rdata_o   (rdata_o),
   .idx       (idx_q),
   .cfg_i     (cfg_i),
   .spec_o_i  (spec_o_i),
   .spec_oe_i (spec_oe_i),
   .pad_o     (pad_o),
   .pad_oe    (pad_oe)
);

// File: tb/gpio_ix_ctrl_test.sv
`timescale 1ns/1ps
module gpio_ix_ctrl_test;
   localparam int NPIN = 22;

   logic              clk = 0;
   logic              rst_n = 0;
   logic              sel_i = 0, port_en_i = 1, addr_i = 0, wr_i = 0, rd_i = 0;
   logic [7:0]        wdata_i = '0;
   logic [7:0]        rdata_o;
   logic [NPIN*8-1:0] cfg_i;
   logic [NPIN-1:0]   pad_in_i = '0, spec_o_i = '0, spec_oe_i = '0;
   logic [NPIN-1:0]   pad_o, pad_oe;

   int checks = 0, fails = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   gpio_ix_ctrl uut (.*);

   // {cfg, latch, pad, spec_o, spec_oe, exp_pad_o, exp_pad_oe, exp_read}
   typedef struct packed {
      logic [7:0] cfg;
      logic l, p, so, soe, eo, eoe, erd;
   } vec_t;
   localparam vec_t VEC [8] = '{
      '{8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
      '{8'h02, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
      '{8'h01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
      '{8'h03, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
      '{8'h08, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
      '{8'h09, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
      '{8'h0A, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
      '{8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}
   };

   task automatic check(string req, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic host_wr(logic a, logic [7:0] d);
      @(negedge clk);
      sel_i = 1; addr_i = a; wr_i = 1; wdata_i = d;
      @(negedge clk);
      sel_i = 0; wr_i = 0;
   endtask

   task automatic host_rd(logic a, output logic [7:0] d);
      @(negedge clk);
      sel_i = 1; addr_i = a; rd_i = 1;
      #1 d = rdata_o;
      @(negedge clk);
      sel_i = 0; rd_i = 0;
   endtask

   task automatic set_cfg(int p, logic [7:0] v);
      cfg_i[p*8 +: 8] = v;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #50000;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      logic [7:0] d;
      for (int p = 0; p < NPIN; p++) cfg_i[p*8 +: 8] = 8'h01;
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R1: pointer and latches after reset
      host_rd(0, d);  check("R1 pointer", d, 8'h00);
      for (int p = 0; p < NPIN; p++) set_cfg(p, 8'h00);
      #1 check("R4 all outputs enabled", pad_oe, {NPIN{1'b1}});
      check("R1 latches clear", pad_o, '0);
      host_wr(0, 8'h01); host_rd(1, d); check("R1 bank A read", d, 8'h00);

      // R2: full pointer width
      host_wr(0, 8'hA5); host_rd(0, d); check("R2 pointer echo", d, 8'hA5);

      // R3 / R6: bank B
      host_wr(0, 8'h02); host_wr(1, 8'hFF);
      host_rd(1, d); check("R6 bank B read", d, 8'h3F);
      check("R3 bank B pads", pad_o[13:8], 6'h3F);
      check("R3 other banks untouched", {pad_o[21:14], pad_o[7:0]}, 16'h0000);

      // R8: out-of-range pointer
      host_wr(0, 8'h04); host_wr(1, 8'h00);
      host_rd(1, d); check("R8 read 0x04", d, 8'h00);
      host_wr(0, 8'h00); host_wr(1, 8'h00);
      host_rd(1, d); check("R8 read 0x00", d, 8'h00);
      check("R8 latches kept", pad_o[13:8], 6'h3F);

      // R9: port closed
      host_wr(0, 8'h02);
      port_en_i = 0;
      host_wr(1, 8'h00);
      host_rd(1, d); check("R9 closed read", d, 8'h00);
      port_en_i = 1;
      host_rd(1, d); check("R9 write ignored", d, 8'h3F);

      // R10: strobes incomplete
      @(negedge clk); sel_i = 1; addr_i = 1; rd_i = 0;
      #1 check("R10 sel without rd", rdata_o, 8'h00);
      @(negedge clk); sel_i = 0; rd_i = 1;
      #1 check("R10 rd without sel", rdata_o, 8'h00);
      @(negedge clk); rd_i = 0;

      // R11: read-modify-write on bank C
      host_wr(0, 8'h03); host_wr(1, 8'h5A);
      host_rd(1, d); host_wr(1, d | 8'h01);
      host_rd(1, d); check("R11 rmw read", d, 8'h5B);
      check("R11 rmw pads", pad_o[21:14], 8'h5B);

      // R7: latch write while pin 30 is special, same cycle as special drive
      set_cfg(14, 8'h08); spec_o_i[14] = 0; spec_oe_i[14] = 1;
      @(negedge clk); sel_i = 1; addr_i = 1; wr_i = 1; wdata_i = 8'hFF;
      @(posedge clk); #1 check("R7 pad follows special during write", {pad_oe[14], pad_o[14]}, 2'b10);
      @(negedge clk); sel_i = 0; wr_i = 0;
      #1 check("R7 pad still special after write", pad_o[14], 1'b0);
      set_cfg(14, 8'h00);
      #1 check("R7 latch shows after release", pad_o[14], 1'b1);

      // vector table on pin 12 (bank A bit 2); R4 R5 R7
      for (int p = 0; p < NPIN; p++) set_cfg(p, 8'h01);
      spec_o_i = '0; spec_oe_i = '0; pad_in_i = '0;
      for (int i = 0; i < 8; i++) begin
         set_cfg(2, VEC[i].cfg);
         pad_in_i[2] = VEC[i].p; spec_o_i[2] = VEC[i].so; spec_oe_i[2] = VEC[i].soe;
         host_wr(0, 8'h01);
         host_wr(1, {5'b0, VEC[i].l, 2'b0});
         #1;
         check($sformatf("R4/R5/R7 vec%0d pad_o", i), pad_o[2], VEC[i].eo);
         check($sformatf("R4/R5/R7 vec%0d pad_oe", i), pad_oe[2], VEC[i].eoe);
         host_rd(1, d);
         check($sformatf("R4/R5/R7 vec%0d read", i), d[2], VEC[i].erd);
      end

      finish_run();
   end
endmodule